// File: doc/BRIEF.md
# Lane-Interleaved Memory Line Parity Unit

This block produces and checks a parity code over one 512-bit memory line. The line is held as two 256-bit read-blocks. Each read-block is spread over 64 memory devices, and each device is 4 bits wide. Every parity bit covers one lane position, that is one bit index inside a device, and it takes that lane from every device in its read-block. An error that stays inside one device therefore flips exactly the parity bits of the lanes that went bad.

In encode mode the block takes a line that is being written back and returns the 8 parity bits to store beside it. In check mode it takes a line read back from memory together with its stored parity. It returns a 4-bit syndrome per read-block that names the lanes holding an odd number of errors, plus a flag per read-block. A caller raises check mode only after some other integrity test has failed on that line. The 4-bit syndrome then narrows the repair search to those lanes of one device.

The result is registered once, so it appears one cycle after the request. A small state register records what the output stage holds. In state ST_IDLE it holds nothing new. In state ST_ENC it holds an encode result, and in state ST_CHK it holds a check result. On every clock the next state is chosen from the request:
- ST_IDLE is chosen when `req_valid` is low. This is the transition "no request", and it can be taken from any state.
- ST_ENC is chosen when `req_valid` is high and `req_check` is low. This is the transition "encode request".
- ST_CHK is chosen when `req_valid` is high and `req_check` is high. This is the transition "check request".

Top module: `lane_parity_unit`

## Requirements
- R1: While reset is held, and on the first negative clock edge after it is released with no request, `res_valid`, `res_parity`, `res_syndrome` and `res_blk_err` are all zero.
- R2: One cycle after a request (`req_valid`=1), `res_parity` bit 4*r+k equals the XOR over devices d=0..63 of `req_line` bit 256*r+4*d+k, for read-block r in 0..1 and lane k in 0..3.
- R3: One cycle after a check request (`req_check`=1), `res_syndrome` equals the `req_parity` of that request XOR the parity from R2.
- R4: One cycle after an encode request (`req_check`=0), `res_syndrome` and `res_blk_err` are zero whatever `req_parity` holds.
- R5: Suppose a line is checked with the correct parity, except that device d of read-block r has its 4-bit nibble XORed with a mask m. Then `res_syndrome[4r+3:4r]` equals m and the syndrome of the other read-block is zero.
- R6: `res_blk_err[r]` is 1 exactly when a check result is held and the syndrome nibble of read-block r is non-zero.
- R7: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Back-to-back requests each give a result one cycle later.
- R8: A cycle with `req_valid` low leaves `res_parity`, `res_syndrome`, `res_blk_err` and `res_check` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_check | input | 1 | 1 = check mode, 0 = encode mode |
| req_line | input | 512 | Memory line; read-block r is bits [256r+255:256r] |
| req_parity | input | 8 | Stored parity, used in check mode only |
| res_valid | output | 1 | Result registered from last cycle's request |
| res_check | output | 1 | Mode of the held result |
| res_parity | output | 8 | Parity computed over the line |
| res_syndrome | output | 8 | Stored XOR computed parity (zero in encode mode) |
| res_blk_err | output | 2 | Per read-block non-zero syndrome flag in check mode |

## Verification
The encode function is driven with all-zero lines, all-one lines, a single walking bit and random lines. The all-one line has 64 ones per lane, so its parity must be zero. The walking bit exposes any lane or read-block mapped to the wrong parity position. Check mode is driven with the correct parity, which must give a zero syndrome. It is also driven with multi-bit masks that stay inside one device of either read-block, which must give exactly the mask in that read-block, and with corrupted stored parity bits. Idle cycles between requests, and encode requests carrying junk stored parity, show that the result holds when no request arrives and that the syndrome is zero in encode mode.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ENC  = 2'd1,
        ST_CHK  = 2'd2
    } lpu_state_e;

endpackage

// File: rtl/lane_parity_gen.sv
// Lane parity for one read-block: parity bit k folds lane k of every device.
module lane_parity_gen #(
    parameter int BLK_W = 256,
    parameter int DEV_W = 4
) (
    input  logic [BLK_W-1:0] blk,
    output logic [DEV_W-1:0] par
);
    localparam int NUM_DEV = BLK_W / DEV_W;

    for (genvar k = 0; k < DEV_W; k++) begin : g_lane
        always_comb begin
            par[k] = 1'b0;
            for (int d = 0; d < NUM_DEV; d++) begin
                par[k] = par[k] ^ blk[d*DEV_W + k];
            end
        end
    end
endmodule

// File: rtl/lane_syndrome_cmp.sv
// Compares stored and recomputed parity per read-block.
module lane_syndrome_cmp #(
    parameter int NUM_BLK = 2,
    parameter int DEV_W   = 4
) (
    input  logic                     chk_en,
    input  logic [NUM_BLK*DEV_W-1:0] calc,
    input  logic [NUM_BLK*DEV_W-1:0] stored,
    output logic [NUM_BLK*DEV_W-1:0] syn,
    output logic [NUM_BLK-1:0]       blk_err
);
    for (genvar r = 0; r < NUM_BLK; r++) begin : g_blk
        always_comb begin
            if (chk_en) begin
                syn[r*DEV_W +: DEV_W] = calc[r*DEV_W +: DEV_W] ^ stored[r*DEV_W +: DEV_W];
            end else begin
                syn[r*DEV_W +: DEV_W] = '0;
            end
            blk_err[r] = |syn[r*DEV_W +: DEV_W];
        end
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LINE_W = 512,
    parameter int BLK_W  = 256,
    parameter int DEV_W  = 4,
    localparam int NUM_BLK = LINE_W / BLK_W,
    localparam int PAR_W   = NUM_BLK * DEV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_check,
    input  logic [LINE_W-1:0] req_line,
    input  logic [PAR_W-1:0]  req_parity,
    output logic              res_valid,
    output logic              res_check,
    output logic [PAR_W-1:0]  res_parity,
    output logic [PAR_W-1:0]  res_syndrome,
    output logic [NUM_BLK-1:0] res_blk_err
);
    lpu_state_e state_q, state_d;

    logic [PAR_W-1:0]   calc_par;
    logic [PAR_W-1:0]   calc_syn;
    logic [NUM_BLK-1:0] calc_err;

    for (genvar r = 0; r < NUM_BLK; r++) begin : g_gen
        lane_parity_gen #(
            .BLK_W (BLK_W),
            .DEV_W (DEV_W)
        ) u_gen (
            .blk (req_line[r*BLK_W +: BLK_W]),
            .par (calc_par[r*DEV_W +: DEV_W])
        );
    end

    lane_syndrome_cmp #(
        .NUM_BLK (NUM_BLK),
        .DEV_W   (DEV_W)
    ) u_cmp (
        .chk_en  (req_check),
        .calc    (calc_par),
        .stored  (req_parity),
        .syn     (calc_syn),
        .blk_err (calc_err)
    );

    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (req_check) begin
            state_d = ST_CHK;
        end else begin
            state_d = ST_ENC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_parity   <= '0;
            res_syndrome <= '0;
            res_blk_err  <= '0;
            res_check    <= 1'b0;
        end else if (req_valid) begin
            res_parity   <= calc_par;
            res_syndrome <= calc_syn;
            res_blk_err  <= calc_err;
            res_check    <= req_check;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: res_valid = 1'b0;
            ST_ENC:  res_valid = 1'b1;
            ST_CHK:  res_valid = 1'b1;
            default: res_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
    parameter int PAR_W   = 8,
    parameter int NUM_BLK = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_check,
    input logic [PAR_W-1:0]   req_parity,
    input logic               res_valid,
    input logic               res_check,
    input logic [PAR_W-1:0]   res_parity,
    input logic [PAR_W-1:0]   res_syndrome,
    input logic [NUM_BLK-1:0] res_blk_err
);
    // R7
    req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R7
    idle_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R3
    syndrome_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_check) |=> (res_syndrome == ($past(req_parity) ^ res_parity)));

    // R4
    enc_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_check) |=> (res_syndrome == '0 && res_blk_err == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_parity) && $stable(res_syndrome)
                        && $stable(res_blk_err) && $stable(res_check)));

    // R6
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_check |-> res_blk_err == '0);
endmodule

bind lane_parity_unit lane_parity_chk #(
    .PAR_W   (PAR_W),
    .NUM_BLK (NUM_BLK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_check    (req_check),
    .req_parity   (req_parity),
    .res_valid    (res_valid),
    .res_check    (res_check),
    .res_parity   (res_parity),
    .res_syndrome (res_syndrome),
    .res_blk_err  (res_blk_err)
);

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_check = 1'b0;
    logic [511:0] req_line = '0;
    logic [7:0]   req_parity = '0;
    logic         res_valid;
    logic         res_check;
    logic [7:0]   res_parity;
    logic [7:0]   res_syndrome;
    logic [1:0]   res_blk_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #4 clk = ~clk;

    lane_parity_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_check    (req_check),
        .req_line     (req_line),
        .req_parity   (req_parity),
        .res_valid    (res_valid),
        .res_check    (res_check),
        .res_parity   (res_parity),
        .res_syndrome (res_syndrome),
        .res_blk_err  (res_blk_err)
    );

    function automatic logic [7:0] ref_par(logic [511:0] l);
        logic [7:0] p = '0;
        for (int i = 0; i < 512; i++) p[(i / 256) * 4 + (i % 4)] ^= l[i];
        return p;
    endfunction

    function automatic logic [511:0] rnd_line();
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference model, updated every clock
    logic       m_valid = 0, m_check = 0;
    logic [7:0] m_par = 0, m_syn = 0;
    logic [1:0] m_err = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_check <= 0; m_par <= 0; m_syn <= 0; m_err <= 0;
        end else begin
            m_valid <= req_valid;
            if (req_valid) begin
                logic [7:0] p, s;
                p = ref_par(req_line);
                s = req_check ? (p ^ req_parity) : 8'h00;
                m_par   <= p;
                m_syn   <= s;
                m_err   <= {s[7:4] != 0, s[3:0] != 0};
                m_check <= req_check;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R7 valid", res_valid, m_valid);
            check("R2 parity", res_parity, m_par);
            check("R3 syndrome", res_syndrome, m_syn);
            check("R6 blk_err", res_blk_err, m_err);
            check("R8 mode", res_check, m_check);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send(logic v, logic c, logic [511:0] l, logic [7:0] p);
        @(negedge clk); #1;
        req_valid = v; req_check = c; req_line = l; req_parity = p;
    endtask

    initial begin
        logic [511:0] l;
        logic [7:0]   p;
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1 valid", res_valid, 0);
        check("R1 parity", res_parity, 0);
        check("R1 syndrome", {res_blk_err, res_syndrome}, 0);
        @(negedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {res_valid, res_parity, res_syndrome, res_blk_err}, 0);
        cmp_en = 1;

        // R2: encode patterns
        send(1, 0, '0, 8'hFF);
        send(1, 0, '1, 8'h5A);
        for (int b = 0; b < 512; b += 37) send(1, 0, 512'd1 << b, 8'h00);
        for (int i = 0; i < 20; i++) send(1, 0, rnd_line(), 8'($urandom));

        // R3: check with correct and corrupted stored parity
        for (int i = 0; i < 10; i++) begin
            l = rnd_line();
            send(1, 1, l, ref_par(l) ^ ((i % 3 == 0) ? 8'(1 << (i % 8)) : 8'h00));
        end

        // R5: device-confined errors in each read-block
        for (int r = 0; r < 2; r++) begin
            for (int m = 1; m < 16; m += 4) begin
                int d;
                l = rnd_line();
                p = ref_par(l);
                d = $urandom_range(63);
                l[r*256 + d*4 +: 4] ^= 4'(m);
                send(1, 1, l, p);
                @(negedge clk);
                check("R5 faulty block", res_syndrome[r*4 +: 4], m);
                check("R5 clean block", res_syndrome[(1-r)*4 +: 4], 0);
                check("R6 flag", res_blk_err, 2'b01 << r);
                #1 req_valid = 0;
            end
        end

        // R8: idle cycles hold the last result
        l = rnd_line();
        send(1, 1, l, ~ref_par(l));
        send(0, 0, rnd_line(), 8'h3C);
        @(negedge clk);
        check("R8 hold syndrome", res_syndrome, 8'hFF);
        check("R7 idle valid", res_valid, 0);
        send(0, 1, rnd_line(), 8'hC3);
        @(negedge clk);
        check("R8 hold parity", res_parity, ref_par(l));

        // R4: encode ignores junk stored parity
        send(1, 0, rnd_line(), 8'hA5);
        @(negedge clk);
        check("R4 encode syndrome", {res_blk_err, res_syndrome}, 0);

        // R7: back-to-back mixed modes
        for (int i = 0; i < 30; i++) begin
            l = rnd_line();
            send(i % 4 != 3, i % 2, l, ref_par(l) ^ 8'($urandom));
        end
        send(0, 0, '0, '0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule